// File: doc/BRIEF.md
# Low-Power Entry and Wake Sequencer

This block decides when a small clock controller stops the system clock and when it brings it back. A register holds enables for three oscillators, a power-down arm bit, a settle-delay enable, a wake interrupt enable and a wake flag. If the arm bit is set when the processor raises its sleep request, the sequencer enters the down state. In that state the system clock enable is low, and the external clock input and the fast internal oscillator are switched off. The slow oscillator keeps running.

A single wake input carries the OR of all wake sources. A wake in the down state clears the arm bit and sets the wake flag. It then reopens the system clock either at once or after a settle count of source ticks. The length of that count depends on which source drives the system clock. The settle counter advances only on `src_tick`, a one-cycle qualifier that stands for a cycle of the selected source. The oscillators are modelled as enable outputs. Their stable flags come back as inputs and are reported in the read word. None of the pins is a data stream, so every pin is a plain control or status level.

Top module: `pdn_seq`

## Requirements
- R1: When `sys_clk_en` is high and `sleep_req` is sampled high at a clock edge with the arm bit (bit 6) set, `pd_active` is high and `sys_clk_en` is low after that edge. With the arm bit clear, a sleep request leaves `sys_clk_en` high.
- R2: While `pd_active` is high, `ext_clk_en`, `fast_osc_en` and `sys_clk_en` are all low, whatever the values of their enable bits and of `sys_src`.
- R3: `slow_osc_en` equals the slow enable bit (bit 2) at all times, including the down state.
- R4: With the delay enable bit (bit 3) set, a wake in the down state holds `sys_clk_en` low until `src_tick` has been sampled high on EXT_DLY edges after the wake edge when `sys_src` is 2'b00 (external), or on FAST_DLY edges when it is 2'b11 (fast internal). Edges where `src_tick` is low do not count.
- R5: A wake in the down state or in the settle phase clears the arm bit. Software has to set it again before the next entry.
- R6: A wake in the down state or in the settle phase sets the wake flag (bit 5). Writing 1 to bit 5 clears the flag whether or not the register is unlocked. A wake in the same cycle as such a write leaves the flag set.
- R7: `wake_irq` is high exactly when the wake flag and the wake interrupt enable bit (bit 4) are both set.
- R8: Bits 0, 1, 2, 3, 4 and 6 change on a write only while `unlock` is high. A locked write leaves them unchanged.
- R9: If the delay enable bit is clear, or `sys_src` is 2'b01 (slow) or 2'b10, then `sys_clk_en` is high right after the edge that samples the wake.
- R10: A wake during the settle phase restarts the count from zero, so the full delay runs again from that wake.
- R11: After reset every register bit is 0, `sys_clk_en` is 1, and all other outputs are 0.
- R12: The read word has the following bit layout: 0 is the external enable, 1 the fast enable, 2 the slow enable, 3 the delay enable, 4 the interrupt enable, 5 the wake flag, 6 the arm bit and 7 `pd_active`. Bits 8, 9 and 10 are the external, fast and slow stable inputs, each ANDed with its enable output. The write word uses the same positions for bits 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 11 | Write word, bit layout as in R12 |
| unlock | input | 1 | Allows writes to the protected bits |
| rd_data | output | 11 | Read word, bit layout as in R12 |
| sleep_req | input | 1 | Processor sleep request |
| wake_evt | input | 1 | OR of all wake sources |
| src_tick | input | 1 | One pulse per cycle of the selected source |
| sys_src | input | 2 | System source: 00 external, 01 slow, 11 fast |
| ext_stable | input | 1 | External clock stable flag |
| fast_stable | input | 1 | Fast oscillator stable flag |
| slow_stable | input | 1 | Slow oscillator stable flag |
| ext_clk_en | output | 1 | External clock input enable |
| fast_osc_en | output | 1 | Fast internal oscillator enable |
| slow_osc_en | output | 1 | Slow internal oscillator enable |
| sys_clk_en | output | 1 | System clock gate enable, 1 = running |
| pd_active | output | 1 | High while in the down state |
| wake_irq | output | 1 | Wake interrupt |

## Verification
Register writes, entry into the down state and the effect of a wake all appear on the outputs immediately after the edge that samples the stimulus. The bench drives inputs 1 ns after a rising edge and reads the outputs 1 ns after the following edge, so each check sees the result of exactly one edge. For the settle delay, the bench counts the edges after the wake edge until `sys_clk_en` rises. It compares that count with EXT_DLY, FAST_DLY or zero, chosen by source and delay bit, and a stalled `src_tick` must add nothing to it. `wake_irq` and the read word are combinational from registers, so they are checked in the same sample as the state change that caused them.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOWN   = 2'd1,
    ST_SETTLE = 2'd2
  } pd_state_e;

  localparam int unsigned REG_W    = 11;
  localparam int unsigned B_EXT    = 0;
  localparam int unsigned B_FAST   = 1;
  localparam int unsigned B_SLOW   = 2;
  localparam int unsigned B_DLY    = 3;
  localparam int unsigned B_IEN    = 4;
  localparam int unsigned B_FLAG   = 5;
  localparam int unsigned B_ARM    = 6;
  localparam int unsigned B_PDA    = 7;
  localparam int unsigned B_EXTOK  = 8;
  localparam int unsigned B_FASTOK = 9;
  localparam int unsigned B_SLOWOK = 10;

  localparam logic [1:0] SRC_EXT  = 2'b00;
  localparam logic [1:0] SRC_SLOW = 2'b01;
  localparam logic [1:0] SRC_FAST = 2'b11;

  typedef struct packed {
    logic arm;
    logic ien;
    logic dly;
    logic slow;
    logic fast;
    logic ext;
  } pd_ctl_t;
endpackage

// File: rtl/pdn_regs.sv
module pdn_regs
  import pdn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             unlock,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wake_hit,
  output pd_ctl_t          ctl,
  output logic             flag
);
  logic prot_wr;
  assign prot_wr = wr_en && unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      flag <= 1'b0;
    end else begin
      if (prot_wr) begin
        ctl.ext  <= wr_data[B_EXT];
        ctl.fast <= wr_data[B_FAST];
        ctl.slow <= wr_data[B_SLOW];
        ctl.dly  <= wr_data[B_DLY];
        ctl.ien  <= wr_data[B_IEN];
        ctl.arm  <= wr_data[B_ARM];
      end
      if (wake_hit) ctl.arm <= 1'b0;
      if (wake_hit) flag <= 1'b1;
      else if (wr_en && wr_data[B_FLAG]) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pdn_wake_timer.sv
module pdn_wake_timer #(
  parameter int unsigned CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] lim,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (start)           cnt <= '0;
    else if (run && tick)     cnt <= cnt + CW'(1);
  end

  assign done = run && tick && !start && (cnt == lim - CW'(1));
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
#(
  parameter int unsigned EXT_DLY  = 4096,
  parameter int unsigned FAST_DLY = 256
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      wake_evt,
  input  logic      src_tick,
  input  logic [1:0] sys_src,
  input  logic      arm,
  input  logic      dly_en,
  output pd_state_e state,
  output logic      wake_hit
);
  localparam int unsigned MAXD = (EXT_DLY > FAST_DLY) ? EXT_DLY : FAST_DLY;
  localparam int unsigned CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] EXT_L  = CW'(EXT_DLY);
  localparam logic [CW-1:0] FAST_L = CW'(FAST_DLY);

  pd_state_e     state_nx;
  logic [CW-1:0] lim_q;
  logic          need_wait;
  logic          cnt_done;

  assign need_wait = dly_en && (sys_src == SRC_EXT || sys_src == SRC_FAST);
  assign wake_hit  = wake_evt && (state != ST_RUN);

  always_comb begin
    state_nx = state;
    case (state)
      ST_RUN:    if (sleep_req && arm) state_nx = ST_DOWN;
      ST_DOWN:   if (wake_evt) state_nx = need_wait ? ST_SETTLE : ST_RUN;
      ST_SETTLE: begin
        if (wake_evt)      state_nx = need_wait ? ST_SETTLE : ST_RUN;
        else if (cnt_done) state_nx = ST_RUN;
      end
      default:   state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      lim_q <= FAST_L;
    end else begin
      state <= state_nx;
      if (wake_hit) lim_q <= (sys_src == SRC_EXT) ? EXT_L : FAST_L;
    end
  end

  pdn_wake_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_hit),
    .run   (state == ST_SETTLE),
    .tick  (src_tick),
    .lim   (lim_q),
    .done  (cnt_done)
  );
endmodule

// File: rtl/pdn_seq.sv
module pdn_seq
  import pdn_pkg::*;
#(
  parameter int unsigned EXT_DLY  = 4096,
  parameter int unsigned FAST_DLY = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [10:0] wr_data,
  input  logic        unlock,
  output logic [10:0] rd_data,
  input  logic        sleep_req,
  input  logic        wake_evt,
  input  logic        src_tick,
  input  logic [1:0]  sys_src,
  input  logic        ext_stable,
  input  logic        fast_stable,
  input  logic        slow_stable,
  output logic        ext_clk_en,
  output logic        fast_osc_en,
  output logic        slow_osc_en,
  output logic        sys_clk_en,
  output logic        pd_active,
  output logic        wake_irq
);
  pd_ctl_t   ctl;
  logic      flag;
  logic      wake_hit;
  pd_state_e state;

  pdn_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .unlock   (unlock),
    .wr_data  (wr_data),
    .wake_hit (wake_hit),
    .ctl      (ctl),
    .flag     (flag)
  );

  pdn_fsm #(.EXT_DLY(EXT_DLY), .FAST_DLY(FAST_DLY)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_evt  (wake_evt),
    .src_tick  (src_tick),
    .sys_src   (sys_src),
    .arm       (ctl.arm),
    .dly_en    (ctl.dly),
    .state     (state),
    .wake_hit  (wake_hit)
  );

  assign pd_active   = (state == ST_DOWN);
  assign sys_clk_en  = (state == ST_RUN);
  assign ext_clk_en  = ctl.ext  && !pd_active;
  assign fast_osc_en = ctl.fast && !pd_active;
  assign slow_osc_en = ctl.slow;
  assign wake_irq    = flag && ctl.ien;

  always_comb begin
    rd_data           = '0;
    rd_data[B_EXT]    = ctl.ext;
    rd_data[B_FAST]   = ctl.fast;
    rd_data[B_SLOW]   = ctl.slow;
    rd_data[B_DLY]    = ctl.dly;
    rd_data[B_IEN]    = ctl.ien;
    rd_data[B_FLAG]   = flag;
    rd_data[B_ARM]    = ctl.arm;
    rd_data[B_PDA]    = pd_active;
    rd_data[B_EXTOK]  = ext_stable  && ext_clk_en;
    rd_data[B_FASTOK] = fast_stable && fast_osc_en;
    rd_data[B_SLOWOK] = slow_stable && slow_osc_en;
  end
endmodule

// File: rtl/pdn_seq_chk.sv
module pdn_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic wake_evt,
  input logic unlock,
  input logic arm_bit,
  input logic dly_bit,
  input logic flag_bit,
  input logic sys_clk_en,
  input logic ext_clk_en,
  input logic fast_osc_en,
  input logic pd_active
);
  a_r1_enter_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en && sleep_req && arm_bit |=> pd_active && !sys_clk_en);

  a_r1_idle_when_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    sys_clk_en && sleep_req && !arm_bit |=> sys_clk_en);

  a_r2_down_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !ext_clk_en && !fast_osc_en && !sys_clk_en);

  a_r5_r6_wake_clears_arm: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && wake_evt |=> !arm_bit && flag_bit);

  a_r8_locked_delay_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> $stable(dly_bit));

  a_r9_no_delay_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active && wake_evt && !dly_bit |=> sys_clk_en);
endmodule

bind pdn_seq pdn_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sleep_req   (sleep_req),
  .wake_evt    (wake_evt),
  .unlock      (unlock),
  .arm_bit     (rd_data[6]),
  .dly_bit     (rd_data[3]),
  .flag_bit    (rd_data[5]),
  .sys_clk_en  (sys_clk_en),
  .ext_clk_en  (ext_clk_en),
  .fast_osc_en (fast_osc_en),
  .pd_active   (pd_active)
);

// File: tb/pdn_seq_bench.sv
`timescale 1ns/1ps
module pdn_seq_bench;
  localparam int EXT_N  = 20;
  localparam int FAST_N = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [10:0] wr_data = '0;
  logic        unlock = 1'b0;
  logic [10:0] rd_data;
  logic        sleep_req = 1'b0;
  logic        wake_evt = 1'b0;
  logic        src_tick = 1'b1;
  logic [1:0]  sys_src = 2'b00;
  logic        ext_stable = 1'b0;
  logic        fast_stable = 1'b0;
  logic        slow_stable = 1'b0;
  logic        ext_clk_en, fast_osc_en, slow_osc_en, sys_clk_en, pd_active, wake_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pdn_seq #(.EXT_DLY(EXT_N), .FAST_DLY(FAST_N)) u_pdn_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .unlock(unlock),
    .rd_data(rd_data), .sleep_req(sleep_req), .wake_evt(wake_evt), .src_tick(src_tick),
    .sys_src(sys_src), .ext_stable(ext_stable), .fast_stable(fast_stable),
    .slow_stable(slow_stable), .ext_clk_en(ext_clk_en), .fast_osc_en(fast_osc_en),
    .slow_osc_en(slow_osc_en), .sys_clk_en(sys_clk_en), .pd_active(pd_active),
    .wake_irq(wake_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [10:0] d, input logic ul);
    wr_en = 1'b1; wr_data = d; unlock = ul;
    step();
    wr_en = 1'b0; wr_data = '0; unlock = 1'b0;
  endtask

  function automatic logic [10:0] mk(input bit e, input bit f, input bit s, input bit d,
                                     input bit i, input bit fl, input bit a);
    logic [10:0] w;
    w = '0;
    w[0] = e; w[1] = f; w[2] = s; w[3] = d; w[4] = i; w[5] = fl; w[6] = a;
    return w;
  endfunction

  function automatic int exp_dly(input logic [1:0] src, input bit d);
    if (!d) return 0;
    if (src == 2'b00) return EXT_N;
    if (src == 2'b11) return FAST_N;
    return 0;
  endfunction

  task automatic enter_down();
    sleep_req = 1'b1;
    step();
    sleep_req = 1'b0;
  endtask

  task automatic count_open(output int n);
    n = 0;
    while (!sys_clk_en && n < 1000) begin
      step();
      n++;
    end
  endtask

  task automatic wake_and_count(output int n);
    wake_evt = 1'b1;
    step();
    wake_evt = 1'b0;
    count_open(n);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R11 reset values
    check("R11 rd_data", int'(rd_data), 0);
    check("R11 sys_clk_en", int'(sys_clk_en), 1);
    check("R11 outputs", int'({ext_clk_en, fast_osc_en, slow_osc_en, pd_active, wake_irq}), 0);

    // R1 sleep without arm keeps clocks running
    sleep_req = 1'b1;
    repeat (4) step();
    sleep_req = 1'b0;
    check("R1 unarmed idle", int'(sys_clk_en), 1);
    check("R1 unarmed no down", int'(pd_active), 0);

    // R8 locked write drops protected bits
    wr(11'h05F, 1'b0);
    check("R8 locked write", int'(rd_data), 0);
    wr(mk(1,0,0,0,0,0,0), 1'b1);
    check("R8 unlocked write", int'(rd_data), int'(mk(1,0,0,0,0,0,0)));

    // R12 stable reporting
    ext_stable = 1'b1; fast_stable = 1'b1; slow_stable = 1'b1;
    step();
    check("R12 stable bits", int'(rd_data[10:8]), 1);
    ext_stable = 1'b0; fast_stable = 1'b0; slow_stable = 1'b0;

    // Sweep over source, delay, interrupt enable and slow enable
    for (int src = 0; src < 4; src++) begin
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < 2; i++) begin
          for (int s = 0; s < 2; s++) begin
            sys_src = 2'(src);
            wr(mk(1,1,s[0],d[0],i[0],1,1), 1'b1);
            check("R6 flag cleared", int'(rd_data[5]), 0);
            enter_down();
            check("R1 armed entry", int'(pd_active), 1);
            check("R2 gated", int'({sys_clk_en, ext_clk_en, fast_osc_en}), 0);
            check("R3 slow in down", int'(slow_osc_en), s);
            check("R12 down bit", int'(rd_data[7]), 1);
            repeat (3) step();
            check("R2 still gated", int'({sys_clk_en, ext_clk_en, fast_osc_en}), 0);
            wake_and_count(n);
            check((exp_dly(2'(src), d[0]) == 0) ? "R9 open delay" : "R4 open delay",
                  n, exp_dly(2'(src), d[0]));
            check("R5 arm cleared", int'(rd_data[6]), 0);
            check("R6 flag set", int'(rd_data[5]), 1);
            check("R7 irq", int'(wake_irq), i);
            check("R2 oscillators back", int'({ext_clk_en, fast_osc_en}), 3);
            wr(mk(0,0,0,0,0,1,0), 1'b0);
            check("R8 R6 locked w1c", int'(rd_data), int'(mk(1,1,s[0],d[0],i[0],0,0)));
            check("R7 irq low", int'(wake_irq), 0);
          end
        end
      end
    end

    // R10 restart on second wake during settle
    sys_src = 2'b00;
    wr(mk(1,1,0,1,0,1,1), 1'b1);
    enter_down();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    repeat (5) step();
    check("R10 still settling", int'(sys_clk_en), 0);
    wake_and_count(n);
    check("R10 restart count", n, EXT_N);

    // R4 stalled ticks do not count
    sys_src = 2'b11;
    wr(mk(1,1,0,1,0,1,1), 1'b1);
    enter_down();
    wake_evt = 1'b1; step(); wake_evt = 1'b0;
    src_tick = 1'b0;
    repeat (30) step();
    check("R4 stalled gated", int'(sys_clk_en), 0);
    src_tick = 1'b1;
    count_open(n);
    check("R4 count after stall", n, FAST_N);

    // R6 wake wins over a same-cycle clear
    wr(mk(1,1,0,0,1,1,1), 1'b1);
    enter_down();
    wake_evt = 1'b1; wr_en = 1'b1; wr_data = mk(0,0,0,0,0,1,0);
    step();
    wake_evt = 1'b0; wr_en = 1'b0; wr_data = '0;
    check("R6 set beats clear", int'(rd_data[5]), 1);
    check("R7 irq after collision", int'(wake_irq), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule